// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is one upward-counting timer channel behind a small memory-mapped register bus. A power-of-two prescaler turns the input clock into count ticks. The counter then either runs freely and wraps at its full width, or runs in interval mode. In interval mode it returns to zero after reaching a programmed limit and raises a pending flag. The flag drives an interrupt line when its enable bit is set. Software stops, resumes and restarts the counter through a control register, and acknowledges the interrupt by reading the status register.

The bus has no back-pressure. An access is the cycle in which both `bus_sel` and `bus_en` are high. A write takes effect at the end of that cycle. Read data is presented combinationally during that same cycle. Any read side effect happens at the edge that ends it. Because every access completes in one cycle, there is no ready signal.

Top module: `ptimer_chan`

## Requirements
- R1: After reset the count is 0 and the counter is stopped, so the counter control register reads 0x01. Clock control, interval, interrupt status and interrupt enable all read 0, and `irq` is low.
- R2: Clock control at offset 0x00 keeps bits 5:0 as written. Bit 0 enables the prescaler, bits 4:1 hold the exponent N and bit 5 is a stored source select. The interval register at offset 0x24 keeps the low CNT_W bits. Interrupt enable at offset 0x60 keeps bit 0. Any offset without a register reads 0.
- R3: Counter control at offset 0x0C reads back bits 0, 1, 2, 3 and 5 as written, and bit 4 always reads 0. Writing 0x23 reads back 0x23, and the counter stays stopped.
- R4: With prescaler bit 0 clear, the count advances once per clock while the counter runs. With bit 0 set, it advances once every 2^(N+1) clocks, counted from a restart.
- R5: While counter control bit 0 is 1 the count holds. The write that sets the bit still allows the tick of that same cycle. After bit 0 is cleared, counting resumes from the held value.
- R6: A counter control write with bit 4 set zeroes the count and the prescaler phase at that edge. This holds even when the same write clears bit 0 or sets it.
- R7: With counter control bit 1 clear, the count runs upward and wraps from 2^CNT_W-1 to 0, and the interrupt status is not set.
- R8: With counter control bit 1 set, a tick that finds the count equal to the interval value loads 0 and sets interrupt status bit 0.
- R9: A read of the interrupt status register at offset 0x54 returns the pending flag in bit 0 and clears it. If an interval event occurs in the same cycle, the flag stays set.
- R10: `irq` is high exactly while interrupt status bit 0 and interrupt enable bit 0 are both 1.
- R11: Writes to the count value at offset 0x18 and to the interrupt status at offset 0x54 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the counter and the prescaler |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Channel selected |
| bus_en | input | 1 | Access phase; together with bus_sel it marks an access cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during a read access cycle |
| irq | output | 1 | Interval interrupt request |

## Verification
The assertions assume that every access cycle is a single cycle with stable address and data. They also assume reads have side effects only when they target the status offset, and that the prescaler exponent is not changed while the counter runs without a later restart. The bench drives every access as exactly one sel-and-enable cycle, starting at a falling edge. It reprograms clock control only while the counter is stopped and always follows a change with a restart. This keeps the tick phase predictable, so the bench can compute each expected count from the number of elapsed edges.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int BUS_W  = 32;
  localparam int PSV_W  = 4;

  localparam logic [7:0] OFS_CLKCTL = 8'h00;
  localparam logic [7:0] OFS_CNTCTL = 8'h0C;
  localparam logic [7:0] OFS_COUNT  = 8'h18;
  localparam logic [7:0] OFS_IVAL   = 8'h24;
  localparam logic [7:0] OFS_ISTAT  = 8'h54;
  localparam logic [7:0] OFS_IEN    = 8'h60;

  localparam int CC_STOP    = 0;
  localparam int CC_IMODE   = 1;
  localparam int CC_RESTART = 4;

  typedef struct packed {
    logic             src;
    logic [PSV_W-1:0] exp_n;
    logic             pre_en;
  } clkctl_t;
endpackage

// File: rtl/ptimer_presc.sv
module ptimer_presc #(
  parameter int PSV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic             pre_en,
  input  logic [PSV_W-1:0] exp_n,
  output logic             tick
);
  localparam int DIV_W = 2 ** PSV_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [PSV_W:0]   shamt;
  logic             wrap;

  always_comb begin
    shamt = {1'b0, exp_n} + (PSV_W+1)'(1);
    mask  = ~({DIV_W{1'b1}} << shamt);
  end

  assign wrap = (div_q == mask);
  assign tick = run & (~pre_en | wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (clr)            div_q <= '0;
    else if (run && pre_en)  div_q <= wrap ? '0 : div_q + DIV_W'(1);
  end
endmodule

// File: rtl/ptimer_count.sv
module ptimer_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             imode,
  input  logic [CNT_W-1:0] ival,
  output logic [CNT_W-1:0] cnt,
  output logic             evt
);
  logic hit;

  assign hit = (cnt == ival);
  assign evt = tick & imode & hit & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= (imode && hit) ? '0 : cnt + CNT_W'(1);
  end
endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              evt,
  output clkctl_t           cc_q,
  output logic              stop_q,
  output logic              imode_q,
  output logic [CNT_W-1:0]  ival_q,
  output logic              ier_q,
  output logic              isr_q,
  output logic              restart,
  output logic              rd_isr
);
  logic       acc, wr_acc, rd_acc;
  logic [2:0] spare_q;

  assign acc    = bus_sel & bus_en;
  assign wr_acc = acc & bus_wr;
  assign rd_acc = acc & ~bus_wr;
  assign rd_isr = rd_acc && (bus_addr == ADDR_W'(OFS_ISTAT));
  assign restart = wr_acc && (bus_addr == ADDR_W'(OFS_CNTCTL)) && bus_wdata[CC_RESTART];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc_q    <= '0;
      stop_q  <= 1'b1;
      imode_q <= 1'b0;
      spare_q <= '0;
      ival_q  <= '0;
      ier_q   <= 1'b0;
    end else if (wr_acc) begin
      if (bus_addr == ADDR_W'(OFS_CLKCTL)) cc_q <= clkctl_t'(bus_wdata[5:0]);
      if (bus_addr == ADDR_W'(OFS_CNTCTL)) begin
        stop_q  <= bus_wdata[CC_STOP];
        imode_q <= bus_wdata[CC_IMODE];
        spare_q <= {bus_wdata[5], bus_wdata[3:2]};
      end
      if (bus_addr == ADDR_W'(OFS_IVAL)) ival_q <= bus_wdata[CNT_W-1:0];
      if (bus_addr == ADDR_W'(OFS_IEN))  ier_q  <= bus_wdata[0];
    end
  end

  // status flag: a new event outranks the clear-on-read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= 1'b0;
    else if (evt)    isr_q <= 1'b1;
    else if (rd_isr) isr_q <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (bus_addr)
        ADDR_W'(OFS_CLKCTL): bus_rdata = BUS_W'(cc_q);
        ADDR_W'(OFS_CNTCTL): bus_rdata = BUS_W'({spare_q[2], 1'b0, spare_q[1:0], imode_q, stop_q});
        ADDR_W'(OFS_COUNT):  bus_rdata = BUS_W'(cnt);
        ADDR_W'(OFS_IVAL):   bus_rdata = BUS_W'(ival_q);
        ADDR_W'(OFS_ISTAT):  bus_rdata = BUS_W'(isr_q);
        ADDR_W'(OFS_IEN):    bus_rdata = BUS_W'(ier_q);
        default:             bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan
  import ptimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  clkctl_t          cc_q;
  logic             stop_q, imode_q, ier_q, isr_q;
  logic             restart, rd_isr, tick, evt;
  logic [CNT_W-1:0] ival_q, cnt_q;

  ptimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt_q), .evt(evt),
    .cc_q(cc_q), .stop_q(stop_q), .imode_q(imode_q), .ival_q(ival_q),
    .ier_q(ier_q), .isr_q(isr_q), .restart(restart), .rd_isr(rd_isr)
  );

  ptimer_presc #(.PSV_W(PSV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(~stop_q), .clr(restart),
    .pre_en(cc_q.pre_en), .exp_n(cc_q.exp_n), .tick(tick)
  );

  ptimer_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(restart),
    .imode(imode_q), .ival(ival_q), .cnt(cnt_q), .evt(evt)
  );

  assign irq = isr_q & ier_q;
endmodule

// File: rtl/ptimer_chan_chk.sv
module ptimer_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             evt,
  input logic             restart,
  input logic             rd_isr,
  input logic             stop_q,
  input logic             imode_q,
  input logic             ier_q,
  input logic             isr_q,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] ival_q
);
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

  a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !restart) |=> $stable(cnt_q));

  a_r8_interval_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && imode_q && (cnt_q == ival_q) && !restart) |=> ((cnt_q == '0) && isr_q));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_isr && !evt) |=> !isr_q);

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> isr_q);

  a_r7_free_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr_q) |-> $past(imode_q));

  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr_q && ier_q));
endmodule

bind ptimer_chan ptimer_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .restart(restart),
  .rd_isr(rd_isr), .stop_q(stop_q), .imode_q(imode_q), .ier_q(ier_q),
  .isr_q(isr_q), .irq(irq), .cnt_q(cnt_q), .ival_q(ival_q)
);

// File: tb/ptimer_chan_bench.sv
`timescale 1ns/1ps
module ptimer_chan_bench;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [31:0] rv;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ptimer_chan #(.CNT_W(CNT_W), .ADDR_W(8)) u_ptimer_chan (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
    end
  endtask

  // each task starts at a falling edge and returns at the next one
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_sel = 1'b1; bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 rv = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(8'h00); check("R1 clkctl", rv, 32'h0);
    rd(8'h0C); check("R1 cntctl", rv, 32'h1);
    rd(8'h18); check("R1 count", rv, 32'h0);
    rd(8'h24); check("R1 interval", rv, 32'h0);
    rd(8'h54); check("R1 status", rv, 32'h0);
    rd(8'h60); check("R1 enable", rv, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 register readback
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00); check("R2 clkctl", rv, 32'h3F);
    wr(8'h00, 32'h0);
    wr(8'h24, 32'h1234_BEEF); rd(8'h24); check("R2 interval", rv, 32'hBEEF);
    wr(8'h60, 32'h1); rd(8'h60); check("R2 enable set", rv, 32'h1);
    wr(8'h60, 32'h0); rd(8'h60); check("R2 enable clear", rv, 32'h0);
    rd(8'h04); check("R2 hole", rv, 32'h0);

    // R3 control readback, 0x23 keeps it stopped
    wr(8'h0C, 32'h23); rd(8'h0C); check("R3 0x23", rv, 32'h23);
    idle(5); rd(8'h18); check("R3 stays stopped", rv, 32'h0);
    wr(8'h0C, 32'h3F); rd(8'h0C); check("R3 restart bit reads 0", rv, 32'h2F);
    rd(8'h18); check("R3 count", rv, 32'h0);

    // R11 writes to read-only offsets
    wr(8'h18, 32'h1234); rd(8'h18); check("R11 count write", rv, 32'h0);
    wr(8'h54, 32'h1); rd(8'h54); check("R11 status write", rv, 32'h0);

    // R4 prescaler sweep: tick every 2^(n+1) clocks after restart
    for (int n = 0; n < 8; n++) begin
      int p;
      p = 1 << (n + 1);
      wr(8'h01, 32'h0);
      wr(8'h00, {27'b0, n[3:0], 1'b1});
      wr(8'h0C, 32'h10);
      idle(p - 1);
      rd(8'h18); check($sformatf("R4 n=%0d before tick", n), rv, 32'h0);
      rd(8'h18); check($sformatf("R4 n=%0d after tick", n), rv, 32'h1);
      wr(8'h0C, 32'h01);
    end
    wr(8'h00, 32'h14);  // exponent set but prescaler off
    wr(8'h0C, 32'h10);
    idle(7); rd(8'h18); check("R4 prescaler off", rv, 32'h7);

    // R5 stop and resume
    wr(8'h0C, 32'h10);
    idle(5);
    wr(8'h0C, 32'h01);
    idle(10); rd(8'h18); check("R5 held", rv, 32'h6);
    wr(8'h0C, 32'h00);
    idle(3); rd(8'h18); check("R5 resumed", rv, 32'h9);

    // R6 restart while running and while stopped
    rd(8'h18); check("R6 running", rv, 32'hA);
    wr(8'h0C, 32'h10); rd(8'h18); check("R6 restart running", rv, 32'h0);
    idle(4);
    wr(8'h0C, 32'h11); idle(3); rd(8'h18); check("R6 restart stopped", rv, 32'h0);

    // R7 free-running wrap
    wr(8'h0C, 32'h10);
    idle(65535); rd(8'h18); check("R7 top", rv, 32'hFFFF);
    rd(8'h18); check("R7 wrap", rv, 32'h0);
    rd(8'h54); check("R7 no flag", rv, 32'h0);
    wr(8'h0C, 32'h01);

    // R8 interval sweep
    for (int iv = 0; iv < 4; iv++) begin
      wr(8'h24, iv);
      wr(8'h0C, 32'h12);
      idle(iv);
      rd(8'h18); check($sformatf("R8 iv=%0d at limit", iv), rv, iv);
      rd(8'h18); check($sformatf("R8 iv=%0d back to 0", iv), rv, 32'h0);
      rd(8'h54); check($sformatf("R8 iv=%0d flag", iv), rv, 32'h1);
      wr(8'h0C, 32'h03);
      rd(8'h54);
    end

    // R9 same-cycle event vs read, R10 gating
    wr(8'h24, 32'h5);
    wr(8'h60, 32'h0);
    wr(8'h0C, 32'h12);
    idle(4);
    rd(8'h18); check("R8 count 4", rv, 32'h4);
    rd(8'h54); check("R9 read before event", rv, 32'h0);
    check("R10 irq off while disabled", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h03);
    rd(8'h18); check("R5 final tick on stop write", rv, 32'h1);
    wr(8'h60, 32'h1);
    check("R10 irq on", {31'b0, irq}, 32'h1);
    rd(8'h54); check("R9 event won", rv, 32'h1);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);
    rd(8'h54); check("R9 cleared", rv, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule